// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two predictors run side by side on every lookup. The first is a pattern table of 2-bit saturating counters, addressed by a global history of recent branch outcomes. The second works in two levels. A per-address history table holds the recent outcomes of the branches that map to each entry. That history then addresses a table of 3-bit saturating counters. A third table of 2-bit selector counters is also addressed by the global history. For each history pattern, it picks whichever of the two component predictions has been right more often.

Lookups use a valid/ready stream. A request carries the fetch address. One cycle after the request is accepted, the direction appears on a registered response channel. That response waits there until the consumer takes it. The response channel applies back-pressure to the request channel: a new request is accepted only when no response is pending or the pending one is taken in the same cycle. Resolved branches arrive on a second stream, which carries the branch address and its actual outcome. Its ready is always high, so every resolve beat is taken in the cycle it is valid. No history is checkpointed. Each resolve retrains the state as it stands in that cycle.

Top module: `tp_tournament_pred`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1. All histories are zero. Global and local counters sit at weakly not-taken (2-bit value 1, 3-bit value 3). Selectors sit at 1. The first prediction is therefore not taken.
- R2: The global counter is addressed by the 12-bit global history. Bit 0 is the most recent outcome, and a 1 means taken. A 2-bit counter predicts taken when its value is 2 or 3.
- R3: The local history entry is addressed by PC bits [11:2]. Its 10-bit history (bit 0 newest, 1 = taken) addresses the 3-bit counter table, and a 3-bit counter predicts taken when its value is 4 or more.
- R4: The selector counter is addressed by the global history. Values 0 and 1 choose the global prediction. Values 2 and 3 choose the local prediction.
- R5: On each resolve beat, the global counter and the local counter selected by the current state each step one toward the outcome. They saturate at 0 and at 3 or 7.
- R6: The selector changes only when the two component predictions for the resolving branch differ. It steps up when the local prediction was correct and down when the global prediction was correct, saturating at 0 and 3.
- R7: After a resolve beat, the global history and the addressed local history entry have each shifted left by one, with the outcome entering at bit 0.
- R8: A request is accepted when req_valid and req_ready are both high. The response is valid in the next cycle. req_ready equals !rsp_valid || rsp_ready. While rsp_valid is high and rsp_ready is low, rsp_taken holds.
- R9: When a request and a resolve are accepted in the same cycle, the prediction uses the tables and histories as they were before that resolve.
- R10: res_ready is always 1, and every resolve beat is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_pc | input | PC_W | Fetch address to predict |
| rsp_valid | output | 1 | Prediction response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_taken | output | 1 | Predicted direction, 1 = taken |
| res_valid | input | 1 | Resolved branch valid |
| res_ready | output | 1 | Resolve stream ready (always 1) |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A lookup and a resolve can land in the same cycle. The lookup then reads the global history, the local history, and all three counter tables while the resolve is writing them. The bench provokes this both in a directed phase, where it looks up and resolves the same address together, and in random traffic, where both streams fire freely over a few shared addresses. A reference model in the bench computes each prediction from its state before it applies the resolve from that cycle. Each response is then judged against that pre-update value.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Component votes that feed the final direction mux.
  typedef struct packed {
    logic glob;
    logic loc;
    logic use_loc;
  } tp_vote_t;

  function automatic logic tp_final(input tp_vote_t v);
    return v.use_loc ? v.loc : v.glob;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
// Array of saturating up/down counters, two combinational read ports, one write port.
module tp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2,
  parameter logic [CTR_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [CTR_W-1:0] rd_a_val,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [CTR_W-1:0] rd_b_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX = '1;

  logic [CTR_W-1:0] cells [DEPTH];

  assign rd_a_val = cells[rd_a_idx];
  assign rd_b_val = cells[rd_b_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= RST_VAL;
    end else if (wr_en) begin
      if (wr_up && cells[wr_idx] != CMAX)
        cells[wr_idx] <= cells[wr_idx] + 1'b1;
      else if (!wr_up && cells[wr_idx] != '0)
        cells[wr_idx] <= cells[wr_idx] - 1'b1;
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
// Per-address outcome history; a write shifts the new outcome into bit 0.
module tp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [HIST_W-1:0] rd_a_hist,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [HIST_W-1:0] rd_b_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist [DEPTH];

  assign rd_a_hist = hist[rd_a_idx];
  assign rd_b_hist = hist[rd_b_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (wr_en) begin
      hist[wr_idx] <= {hist[wr_idx][HIST_W-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/tp_tournament_pred.sv
module tp_tournament_pred #(
  parameter int PC_W      = 32,
  parameter int GH_W      = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LH_W      = 10,
  parameter int GCTR_W    = 2,
  parameter int LCTR_W    = 3,
  parameter int SEL_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PC_W-1:0] req_pc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_taken,
  input  logic            res_valid,
  output logic            res_ready,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken
);
  import tp_pkg::*;

  // Weak not-taken for the components, weak preference for global in the selector.
  localparam logic [GCTR_W-1:0] G_RST = GCTR_W'((1 << (GCTR_W-1)) - 1);
  localparam logic [LCTR_W-1:0] L_RST = LCTR_W'((1 << (LCTR_W-1)) - 1);
  localparam logic [SEL_W-1:0]  S_RST = SEL_W'((1 << (SEL_W-1)) - 1);
  localparam int PC_LO = 2;
  localparam int PC_HI = PC_LO + LHT_IDX_W - 1;

  logic [GH_W-1:0]      ghr_q;
  logic [LH_W-1:0]      lh_req, lh_res;
  logic [GCTR_W-1:0]    g_req, g_res;
  logic [LCTR_W-1:0]    l_req, l_res;
  logic [SEL_W-1:0]     s_req, s_res;
  tp_vote_t             vote_req, vote_res;
  logic                 req_fire;
  logic                 sel_train;

  assign res_ready = 1'b1;
  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LH_W)) lht_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(req_pc[PC_HI:PC_LO]), .rd_a_hist(lh_req),
    .rd_b_idx(res_pc[PC_HI:PC_LO]), .rd_b_hist(lh_res),
    .wr_en(res_valid), .wr_idx(res_pc[PC_HI:PC_LO]), .wr_bit(res_taken)
  );

  tp_ctr_table #(.IDX_W(GH_W), .CTR_W(GCTR_W), .RST_VAL(G_RST)) gtab_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ghr_q), .rd_a_val(g_req),
    .rd_b_idx(ghr_q), .rd_b_val(g_res),
    .wr_en(res_valid), .wr_idx(ghr_q), .wr_up(res_taken)
  );

  tp_ctr_table #(.IDX_W(LH_W), .CTR_W(LCTR_W), .RST_VAL(L_RST)) ltab_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(lh_req), .rd_a_val(l_req),
    .rd_b_idx(lh_res), .rd_b_val(l_res),
    .wr_en(res_valid), .wr_idx(lh_res), .wr_up(res_taken)
  );

  tp_ctr_table #(.IDX_W(GH_W), .CTR_W(SEL_W), .RST_VAL(S_RST)) stab_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ghr_q), .rd_a_val(s_req),
    .rd_b_idx(ghr_q), .rd_b_val(s_res),
    .wr_en(sel_train), .wr_idx(ghr_q), .wr_up(vote_res.loc == res_taken)
  );

  always_comb begin
    vote_req.glob    = g_req[GCTR_W-1];
    vote_req.loc     = l_req[LCTR_W-1];
    vote_req.use_loc = s_req[SEL_W-1];
    vote_res.glob    = g_res[GCTR_W-1];
    vote_res.loc     = l_res[LCTR_W-1];
    vote_res.use_loc = s_res[SEL_W-1];
  end

  assign sel_train = res_valid && (vote_res.glob != vote_res.loc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghr_q <= '0;
    end else if (res_valid) begin
      ghr_q <= {ghr_q[GH_W-2:0], res_taken};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_taken <= 1'b0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_taken <= tp_final(vote_req);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tp_tournament_chk.sv
module tp_tournament_chk #(
  parameter int GH_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_taken,
  input logic            res_valid,
  input logic            res_taken,
  input logic [GH_W-1:0] ghr
);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_taken));
  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
  // R7
  ghr_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> ghr[0] == $past(res_taken));
  // R7
  ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> ghr[GH_W-1:1] == $past(ghr[GH_W-2:0]));
  // R7
  ghr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(ghr));
endmodule

bind tp_tournament_pred tp_tournament_chk #(.GH_W(GH_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_taken(rsp_taken),
  .res_valid(res_valid), .res_taken(res_taken), .ghr(ghr_q)
);

// File: tb/tp_tournament_pred_tb_top.sv
module tp_tournament_pred_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0, res_valid = 1'b0, res_taken = 1'b0;
  logic [PC_W-1:0] req_pc = '0, res_pc = '0;
  logic req_ready, rsp_valid, rsp_taken, res_ready;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tp_tournament_pred dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_taken(rsp_taken),
    .res_valid(res_valid), .res_ready(res_ready), .res_pc(res_pc),
    .res_taken(res_taken)
  );

  // Reference state built from the requirements.
  logic [1:0]  m_g [4096];
  logic [2:0]  m_l [1024];
  logic [1:0]  m_s [4096];
  logic [9:0]  m_h [1024];
  logic [11:0] m_ghr;
  logic        m_rv, m_rt;

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) begin m_g[i] = 2'd1; m_s[i] = 2'd1; end
    for (int i = 0; i < 1024; i++) begin m_l[i] = 3'd3; m_h[i] = '0; end
    m_ghr = '0; m_rv = 1'b0; m_rt = 1'b0;
  endtask

  function automatic logic model_pred(input logic [PC_W-1:0] pc);
    logic gp, lp;
    gp = m_g[m_ghr] >= 2;
    lp = m_l[m_h[pc[11:2]]] >= 4;
    return (m_s[m_ghr] >= 2) ? lp : gp;
  endfunction

  task automatic model_resolve(input logic [PC_W-1:0] pc, input logic t);
    logic [9:0] h;
    logic gp, lp;
    h = m_h[pc[11:2]];
    gp = m_g[m_ghr] >= 2;
    lp = m_l[h] >= 4;
    if (t) begin
      if (m_g[m_ghr] != 2'd3) m_g[m_ghr] = m_g[m_ghr] + 1;
      if (m_l[h] != 3'd7) m_l[h] = m_l[h] + 1;
    end else begin
      if (m_g[m_ghr] != 2'd0) m_g[m_ghr] = m_g[m_ghr] - 1;
      if (m_l[h] != 3'd0) m_l[h] = m_l[h] - 1;
    end
    if (gp != lp) begin
      if (lp == t) begin if (m_s[m_ghr] != 2'd3) m_s[m_ghr] = m_s[m_ghr] + 1; end
      else         begin if (m_s[m_ghr] != 2'd0) m_s[m_ghr] = m_s[m_ghr] - 1; end
    end
    m_h[pc[11:2]] = {h[8:0], t};
    m_ghr = {m_ghr[10:0], t};
  endtask

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check, advance the model, wait one clock.
  task automatic step(input logic rv, input logic [PC_W-1:0] pc, input logic rdy,
                      input logic sv, input logic [PC_W-1:0] spc, input logic st,
                      input string tag);
    logic acc, p;
    req_valid = rv; req_pc = pc; rsp_ready = rdy;
    res_valid = sv; res_pc = spc; res_taken = st;
    #1;
    check(tag, rsp_valid, m_rv, "rsp_valid");
    if (m_rv) check(tag, rsp_taken, m_rt, "rsp_taken");
    check(tag, req_ready, !m_rv || rdy, "req_ready");
    check("R10", res_ready, 1'b1, "res_ready");
    acc = rv && (!m_rv || rdy);
    p = model_pred(pc);
    if (sv) model_resolve(spc, st);
    if (acc) begin m_rv = 1'b1; m_rt = p; end
    else if (rdy) m_rv = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and first prediction
    step(1'b1, 32'h1000, 1'b1, 1'b0, '0, 1'b0, "R1");
    check("R1", rsp_taken, 1'b0, "first prediction");
    step(1'b0, '0, 1'b1, 1'b0, '0, 1'b0, "R1");

    // R2 R5: always-taken branch drives the global counters to saturation
    for (int i = 0; i < 40; i++)
      step(1'b1, 32'h2040, 1'b1, 1'b1, 32'h2040, 1'b1, "R2 R5");
    step(1'b1, 32'h2040, 1'b1, 1'b0, '0, 1'b0, "R2 R5");
    step(1'b0, '0, 1'b1, 1'b0, '0, 1'b0, "R2");
    check("R2", rsp_valid, 1'b0, "drained");

    // R3 R6: alternating branch, local history learns the pattern
    for (int i = 0; i < 80; i++)
      step(1'b1, 32'h0abc, 1'b1, 1'b1, 32'h0abc, i[0], "R3 R6");

    // R8: back-pressure holds the response
    step(1'b1, 32'h0abc, 1'b1, 1'b0, '0, 1'b0, "R8");
    for (int i = 0; i < 5; i++)
      step(1'b1, 32'h0444, 1'b0, 1'b1, 32'h0444, 1'b1, "R8");
    step(1'b1, 32'h0444, 1'b1, 1'b0, '0, 1'b0, "R8");
    step(1'b0, '0, 1'b1, 1'b0, '0, 1'b0, "R8");

    // R9: lookup and resolve of the same address in one cycle
    for (int i = 0; i < 20; i++)
      step(1'b1, 32'h0f00, 1'b1, 1'b1, 32'h0f00, (i % 3) != 0, "R9");

    // R4 R6 R7 R10: random mixed traffic over a few shared addresses
    for (int i = 0; i < 4000; i++) begin
      logic [PC_W-1:0] a, b;
      logic t;
      a = 32'h3000 + ({29'd0, 3'($urandom)} << 2);
      b = 32'h3000 + ({29'd0, 3'($urandom)} << 2);
      t = (b[4:2] < 3'd3) ? (($urandom % 8) != 0) : (($urandom % 2) == 0);
      if (b[4:2] == 3'd5) t = m_ghr[1];
      step(1'($urandom), a, ($urandom % 4) != 0, ($urandom % 3) != 0, b, t,
           "R4 R6 R7 R10");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule